// File: doc/BRIEF.md
# Pulse-Width Bit Signal Classifier

This block is the slave-side front end of a single-wire bus on which every symbol is a low pulse driven from an idle-high line. The block brings the raw line into the clock domain and measures how long each pulse stays low, starting at the falling edge. When the line goes high again it sorts the pulse into one of five symbols by comparing the measured time against a ladder of thresholds. The symbols are data 0, data 1, start, attention and bus reset. A longer pulse always takes precedence over the shorter classes it passes through.

The transaction layer above receives a one-clock symbol strobe with a 3-bit code. It also receives an abort strobe when a start symbol ends while that layer reports a transaction in progress. During a read slot the transaction layer states the bit to return. When that bit is 1, the block pulls the line low shortly after the master's falling edge and holds it for a fixed time, which stretches the pulse into a data 1. A falling edge that comes before the line has been high for the inactive time is not taken as a symbol. All times are parameters counted in clock cycles.

Top module: `pwb_rx_top`

## Requirements
- R1: While reset is held and in the first cycles after it, sym_valid_o, abort_o and line_pull_o are 0.
- R2: Symbol codes are D0=0, D1=1, START=2, ATTN=3, RESET=4. A pulse of L synchronized low cycles with L < T_D1 reports D0. A pulse with T_D1 <= L < T_START reports D1.
- R3: A pulse with T_START <= L < T_ATTN reports START.
- R4: abort_o pulses together with sym_valid_o only for a START symbol that ends while txn_active_i is 1. Any other symbol, and a START ending while txn_active_i is 0, leaves abort_o at 0.
- R5: A pulse with T_ATTN <= L < T_RESET reports ATTN.
- R6: A pulse with L >= T_RESET reports RESET, including pulses far longer than T_RESET. The low-time counter saturates.
- R7: Each accepted symbol gives exactly one sym_valid_o cycle. That cycle starts SYNC_STAGES+1 clock edges after the line returns high.
- R8: A falling edge seen after fewer than T_INACT synchronized high cycles is ignored. It produces no strobe and no pull. After at least T_INACT high cycles the falling edge is accepted.
- R9: If rd_slot_i=1 and rd_bit_i=1 at an accepted falling edge, line_pull_o rises SYNC_STAGES+1 edges after the raw fall and stays high for exactly T_OUT1 cycles. With the default thresholds the stretched pulse reports D1.
- R10: If rd_slot_i=1 and rd_bit_i=0, line_pull_o stays 0 and a short master pulse reports D0.
- R11: After a RESET symbol no training state exists. The eight short pulses that follow each report D0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Raw bus level (1 = released) |
| rd_slot_i | input | 1 | Next pulse is a read slot |
| rd_bit_i | input | 1 | Bit value to answer in the read slot |
| txn_active_i | input | 1 | Transaction layer has a transaction open |
| line_pull_o | output | 1 | Drive the bus low while 1 |
| sym_valid_o | output | 1 | One-cycle strobe for a classified symbol |
| sym_code_o | output | 3 | Symbol code (D0=0, D1=1, START=2, ATTN=3, RESET=4) |
| abort_o | output | 1 | One-cycle strobe: start symbol aborted an open transaction |

## Verification
The bench drives pulses of exactly T-1 and T cycles at every threshold. A comparator with an off-by-one error would put one of each pair into the wrong class. A pulse far beyond the reset threshold exposes a counter that wraps instead of saturating, which would report a short symbol. A pulse arriving after one cycle too few of idle time, with a read-1 request pending, catches a design that ignores the inactive gate: it would emit an extra symbol and pull the line. The read-1 slot checks when the pull starts and how long it lasts, and a design that answered a 0 request by driving the line would stretch the pulse into a data 1.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    typedef enum logic [2:0] {
        SYM_D0    = 3'd0,
        SYM_D1    = 3'd1,
        SYM_START = 3'd2,
        SYM_ATTN  = 3'd3,
        SYM_RESET = 3'd4
    } sym_e;

    typedef struct packed {
        logic valid;
        sym_e code;
        logic abort;
    } sym_out_t;

    // Longest threshold reached wins; between thresholds the shorter class holds.
    function automatic sym_e classify(input int unsigned n,
                                      input int unsigned t_d1,
                                      input int unsigned t_start,
                                      input int unsigned t_attn,
                                      input int unsigned t_reset);
        sym_e s;
        if (n >= t_reset)      s = SYM_RESET;
        else if (n >= t_attn)  s = SYM_ATTN;
        else if (n >= t_start) s = SYM_START;
        else if (n >= t_d1)    s = SYM_D1;
        else                   s = SYM_D0;
        return s;
    endfunction

endpackage

// File: rtl/pwb_line_sync.sv
module pwb_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw_i,
    output logic lvl_o,
    output logic fall_o,
    output logic rise_o
);
    // sh[STAGES-1] is the synchronized level, sh[STAGES] the previous one.
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-1:0], raw_i};
    end

    assign lvl_o  = sh[STAGES-1];
    assign fall_o = sh[STAGES] & ~sh[STAGES-1];
    assign rise_o = ~sh[STAGES] & sh[STAGES-1];
endmodule

// File: rtl/pwb_low_timer.sv
module pwb_low_timer #(
    parameter int unsigned T_RESET = 32,
    parameter int unsigned T_INACT = 4,
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned IDLE_W  = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lvl_i,
    input  logic             fall_i,
    input  logic             rise_i,
    output logic             accept_o,
    output logic             end_o,
    output logic [CNT_W-1:0] low_cnt_o
);
    localparam logic [CNT_W-1:0]  LOW_MAX  = CNT_W'(T_RESET);
    localparam logic [CNT_W-1:0]  LOW_ONE  = CNT_W'(1);
    localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(T_INACT);
    localparam logic [IDLE_W-1:0] IDLE_ONE = IDLE_W'(1);

    logic              busy;
    logic [IDLE_W-1:0] idle_cnt;
    logic [CNT_W-1:0]  low_cnt;

    assign accept_o  = fall_i && (idle_cnt == IDLE_MAX);
    assign end_o     = rise_i && busy;
    assign low_cnt_o = low_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            low_cnt  <= '0;
            idle_cnt <= '0;
        end else begin
            if (lvl_i)
                idle_cnt <= (idle_cnt == IDLE_MAX) ? idle_cnt : idle_cnt + IDLE_ONE;
            else
                idle_cnt <= '0;

            if (accept_o) begin
                busy    <= 1'b1;
                low_cnt <= LOW_ONE;
            end else if (end_o) begin
                busy    <= 1'b0;
            end else if (busy && !lvl_i && (low_cnt != LOW_MAX)) begin
                low_cnt <= low_cnt + LOW_ONE;
            end
        end
    end
endmodule

// File: rtl/pwb_read_responder.sv
module pwb_read_responder #(
    parameter int unsigned T_OUT1 = 6,
    parameter int unsigned PULL_W = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    input  logic rd_slot_i,
    input  logic rd_bit_i,
    output logic pull_o
);
    localparam logic [PULL_W-1:0] PULL_LEN = PULL_W'(T_OUT1);
    localparam logic [PULL_W-1:0] PULL_ONE = PULL_W'(1);

    logic [PULL_W-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)                                left <= '0;
        else if (trig_i && rd_slot_i && rd_bit_i) left <= PULL_LEN;
        else if (left != '0)                    left <= left - PULL_ONE;
    end

    assign pull_o = (left != '0);
endmodule

// File: rtl/pwb_rx_top.sv
module pwb_rx_top
    import pwb_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned T_D1        = 6,
    parameter int unsigned T_START     = 12,
    parameter int unsigned T_ATTN      = 20,
    parameter int unsigned T_RESET     = 32,
    parameter int unsigned T_INACT     = 4,
    parameter int unsigned T_OUT1      = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    input  logic       rd_slot_i,
    input  logic       rd_bit_i,
    input  logic       txn_active_i,
    output logic       line_pull_o,
    output logic       sym_valid_o,
    output logic [2:0] sym_code_o,
    output logic       abort_o
);
    localparam int unsigned CNT_W  = $clog2(T_RESET + 1);
    localparam int unsigned IDLE_W = $clog2(T_INACT + 1);
    localparam int unsigned PULL_W = $clog2(T_OUT1 + 1);

    logic             lvl, fall, rise;
    logic             accept, sym_end;
    logic [CNT_W-1:0] low_cnt;
    sym_e             cls;
    sym_out_t         out_q;

    pwb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (line_i),
        .lvl_o  (lvl),
        .fall_o (fall),
        .rise_o (rise)
    );

    pwb_low_timer #(
        .T_RESET (T_RESET),
        .T_INACT (T_INACT),
        .CNT_W   (CNT_W),
        .IDLE_W  (IDLE_W)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .lvl_i     (lvl),
        .fall_i    (fall),
        .rise_i    (rise),
        .accept_o  (accept),
        .end_o     (sym_end),
        .low_cnt_o (low_cnt)
    );

    pwb_read_responder #(.T_OUT1(T_OUT1), .PULL_W(PULL_W)) u_resp (
        .clk       (clk),
        .rst       (rst),
        .trig_i    (accept),
        .rd_slot_i (rd_slot_i),
        .rd_bit_i  (rd_bit_i),
        .pull_o    (line_pull_o)
    );

    assign cls = classify(32'(low_cnt), T_D1, T_START, T_ATTN, T_RESET);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '{valid: 1'b0, code: SYM_D0, abort: 1'b0};
        end else begin
            out_q.valid <= sym_end;
            out_q.code  <= cls;
            out_q.abort <= sym_end && (cls == SYM_START) && txn_active_i;
        end
    end

    assign sym_valid_o = out_q.valid;
    assign sym_code_o  = out_q.code;
    assign abort_o     = out_q.abort;
endmodule

// File: rtl/pwb_rx_checker.sv
module pwb_rx_checker (
    input logic       clk,
    input logic       rst,
    input logic       rd_slot_i,
    input logic       rd_bit_i,
    input logic       txn_active_i,
    input logic       line_pull_o,
    input logic       sym_valid_o,
    input logic [2:0] sym_code_o,
    input logic       abort_o
);
    p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
        sym_valid_o |=> !sym_valid_o);

    p_abort_on_start_r4: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> (sym_valid_o && sym_code_o == 3'd2));

    p_abort_needs_txn_r4: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> $past(txn_active_i));

    p_code_legal_r2: assert property (@(posedge clk) disable iff (rst)
        sym_valid_o |-> (sym_code_o <= 3'd4));

    p_pull_requested_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(line_pull_o) |-> $past(rd_slot_i && rd_bit_i));
endmodule

bind pwb_rx_top pwb_rx_checker u_chk (.*);

// File: tb/tb_pwb_rx_top.sv
`timescale 1ns/1ps
module tb_pwb_rx_top;
    localparam int SYNC = 2, TD1 = 6, TST = 12, TAT = 20, TRS = 32, TIN = 4, TO1 = 6;
    localparam int NV = 12;
    localparam int V_LEN [NV] = '{1, 5, 6, 11, 12, 19, 20, 31, 32, 12, 20, 6};
    localparam int V_TXN [NV] = '{0, 1, 0, 1,  0,  1,  1,  1,  1,  1,  0, 1};
    localparam int V_COD [NV] = '{0, 0, 1, 1,  2,  2,  3,  3,  4,  2,  3, 1};
    localparam int V_ABT [NV] = '{0, 0, 0, 0,  0,  1,  0,  0,  0,  1,  0, 0};

    logic clk = 0, rst = 1, mline = 1, rd_slot = 0, rd_bit = 0, txn = 0;
    logic line, pull, sv, ab;
    logic [2:0] code;
    int n_chk = 0, n_bad = 0, n_str = 0, n_pull = 0, last_code = 0, last_ab = 0;
    bit done = 0;

    always #2.5 clk = ~clk;
    assign line = mline & ~pull;

    pwb_rx_top dut (.clk(clk), .rst(rst), .line_i(line), .rd_slot_i(rd_slot),
        .rd_bit_i(rd_bit), .txn_active_i(txn), .line_pull_o(pull),
        .sym_valid_o(sv), .sym_code_o(code), .abort_o(ab));

    always @(negedge clk) if (!rst) begin
        if (sv) begin n_str++; last_code = int'(code); last_ab = int'(ab); end
        if (pull) n_pull++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Drive a low pulse, return latency of the strobe after release.
    task automatic pulse(input int len, output int lat);
        mline = 0;
        repeat (len) @(negedge clk);
        mline = 1;
        lat = -1;
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (sv && lat < 0) lat = k;
        end
        repeat (TIN + 2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int lat, s0, p0, cnt_ok;
        // R1: reset state
        repeat (4) @(negedge clk);
        check(!sv && !ab && !pull, "R1 during reset", int'({sv, ab, pull}), 0);
        rst = 0;
        repeat (TIN + 4) @(negedge clk);
        check(!sv && !ab && !pull && n_str == 0, "R1 after reset", int'({sv, ab, pull}), 0);

        // Table walk: R2 R3 R4 R5 R6 R7
        for (int i = 0; i < NV; i++) begin
            txn = V_TXN[i][0];
            s0 = n_str;
            pulse(V_LEN[i], lat);
            check(n_str - s0 == 1, "R7 one strobe", n_str - s0, 1);
            check(lat == SYNC + 1, "R7 latency", lat, SYNC + 1);
            check(last_code == V_COD[i], "R2/R3/R5/R6 code", last_code, V_COD[i]);
            check(last_ab == V_ABT[i], "R4 abort", last_ab, V_ABT[i]);
        end
        txn = 0;

        // R6: very long pulse saturates to RESET; then R11 training bits as D0
        s0 = n_str;
        pulse(3 * TRS + 7, lat);
        check(last_code == 4 && n_str - s0 == 1, "R6 long reset", last_code, 4);
        cnt_ok = 0;
        for (int i = 0; i < 8; i++) begin
            pulse(3, lat);
            if (last_code == 0) cnt_ok++;
        end
        check(n_str - s0 == 9 && cnt_ok == 8, "R11 training bits D0", cnt_ok, 8);

        // R8: short inactive gap ignored (with read-1 pending)
        s0 = n_str; p0 = n_pull;
        mline = 0; repeat (3) @(negedge clk); mline = 1;
        rd_slot = 1; rd_bit = 1;
        repeat (TIN - 1) @(negedge clk);
        mline = 0; repeat (8) @(negedge clk); mline = 1;
        repeat (12) @(negedge clk);
        check(n_str - s0 == 1, "R8 short gap strobes", n_str - s0, 1);
        check(last_code == 0, "R8 short gap code", last_code, 0);
        check(n_pull == p0, "R8 no pull", n_pull - p0, 0);
        rd_slot = 0; rd_bit = 0;
        repeat (TIN + 2) @(negedge clk);

        // R8: exact inactive gap accepted
        s0 = n_str;
        mline = 0; repeat (3) @(negedge clk); mline = 1;
        repeat (TIN) @(negedge clk);
        mline = 0; repeat (8) @(negedge clk); mline = 1;
        repeat (12) @(negedge clk);
        check(n_str - s0 == 2, "R8 exact gap strobes", n_str - s0, 2);
        check(last_code == 1, "R8 exact gap code", last_code, 1);

        // R9: read slot answering 1
        rd_slot = 1; rd_bit = 1;
        s0 = n_str; p0 = 0; lat = -1;
        mline = 0;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (pull) begin p0++; if (lat < 0) lat = k; end
            if (k == 3) mline = 1;
        end
        rd_slot = 0; rd_bit = 0;
        check(lat == SYNC + 1, "R9 pull start", lat, SYNC + 1);
        check(p0 == TO1, "R9 pull length", p0, TO1);
        check(n_str - s0 == 1 && last_code == 1, "R9 stretched D1", last_code, 1);
        repeat (TIN + 2) @(negedge clk);

        // R10: read slot answering 0
        rd_slot = 1; rd_bit = 0;
        s0 = n_str; p0 = n_pull;
        pulse(3, lat);
        check(n_pull == p0, "R10 no pull", n_pull - p0, 0);
        check(n_str - s0 == 1 && last_code == 0, "R10 D0", last_code, 0);
        rd_slot = 0;

        // R1: reset mid-pulse clears outputs
        mline = 0; repeat (5) @(negedge clk);
        rst = 1; @(negedge clk); @(negedge clk);
        check(!sv && !ab && !pull, "R1 mid reset", int'({sv, ab, pull}), 0);
        mline = 1;
        finish_run();
    end
endmodule